// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a synchronous static memory with burst access. The array holds `2**ADDR_W` words. Each word is split into `LANES` byte lanes of `LANE_W` bits, so the defaults give 18-bit words built from two 9-bit lanes. Address and control are registered on every rising edge. Read data leaves through an output register, which adds one pipeline stage.

A burst can open in two ways. The processor strobe opens a burst that is always a read. The controller strobe opens a burst that is a read or a write, depending on the write enables seen on the same edge. The two strobes follow different chip-select rules. After the opening edge, an advance input steps a small wrap-around counter through the low address bits. The counter follows linear or interleaved order. A pin picks the order, or a parameter fixes it.

Writes use either a global enable or a byte-write enable qualified by per-lane strobes. A write strobe seen on an edge switches the data drivers off. Outside that case the drivers follow the output-enable pin.

Top module: `pburst_sram`

## Requirements
- R1: A read access registered on rising edge k appears on `dout` after edge k+1, with `dq_drive` high when `oe_n` is low. After edge k itself, `dq_drive` is still low if no earlier read was pending.
- R2: An edge with `proc_strobe_n` low and all three chip enables active (`ce_main_n`=0, `ce_hi`=1, `ce_lo_n`=0) opens a read burst at `addr`. `gwe_n`, `bwe_n`, `lane_we_n`, `ctrl_strobe_n` and `din` have no effect on that edge, and the memory is not changed.
- R3: An edge with `ctrl_strobe_n` low and `proc_strobe_n` high, with the secondary enables active, opens a burst at `addr`. The write enables sampled on that same edge decide whether the first beat writes `din` or reads.
- R4: `ce_main_n` high blocks a start by the processor strobe but not one by the controller strobe. `ce_hi` low or `ce_lo_n` high blocks both kinds of start. A controller-strobe edge with the secondary enables inactive ends the current burst, so later edges access nothing.
- R5: `adv_n` is ignored on an edge that opens a burst. On a later edge with both strobes high, `adv_n` low steps the burst counter and that edge accesses the next address. `adv_n` high accesses the same address again. This holds for reads and for writes.
- R6: Beat c of a burst opened at base address b keeps the upper address bits of b. Its two low bits are `b[1:0] ^ c` when `ilv_order`=1, and `(b[1:0] + c) mod 4` when `ilv_order`=0.
- R7: On a write-capable edge: `gwe_n`=0 writes every lane. With `gwe_n`=1 and `bwe_n`=0, only the lanes with `lane_we_n[i]`=0 are written. Lane i is `din`/`dout` bits `[LANE_W*i +: LANE_W]`. The edge is a read, and leaves memory unchanged, when `gwe_n`=1 with `bwe_n`=1, or when `bwe_n`=0 with every `lane_we_n` bit high.
- R8: After any edge where `proc_strobe_n` is high and a write strobe is effective (`gwe_n`=0, or `bwe_n`=0 with some `lane_we_n` bit low), `dq_drive` is low whatever `oe_n` is. This holds even if a read result was due on that edge.
- R9: `dq_drive` is high only while `oe_n` is low and a read result is held. `oe_n` acts on `dq_drive` without waiting for a clock edge.
- R10: Reads return the latest contents written, including a write on the edge just before the read. After reset, `dq_drive` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| addr | input | ADDR_W | Burst start address |
| proc_strobe_n | input | 1 | Processor strobe, opens a read burst |
| ctrl_strobe_n | input | 1 | Controller strobe, opens a read or write burst |
| adv_n | input | 1 | Burst advance, active low |
| gwe_n | input | 1 | Global write, all lanes |
| bwe_n | input | 1 | Byte-write qualifier |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| ce_main_n | input | 1 | Master chip enable, active low |
| ce_hi | input | 1 | Secondary chip enable, active high |
| ce_lo_n | input | 1 | Secondary chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ilv_order | input | 1 | Burst order: 1 interleaved, 0 linear |
| din | input | LANE_W*LANES | Write data |
| dout | output | LANE_W*LANES | Registered read data |
| dq_drive | output | 1 | High when the data bus is driven |

## Verification
A write lands in the array on the edge that samples it. A read result for edge k is due after edge k+1. The `oe_n` gate acts on `dq_drive` at once, with no edge. The bench drives inputs on the falling edge and samples right after the edge on which each result is due. It checks each burst beat one edge behind the beat that issued it, and it checks for no drive after the start edge of a read taken from idle. Expected words come from an arithmetic data pattern and from a shadow array updated by the same lane-mask rule as R7. The sweep covers every base address in both burst orders, then the chip-enable, write-kill and output-enable corners.

// File: rtl/psram_pkg.sv
package psram_pkg;

   // burst order variants chosen at elaboration
   localparam int ORD_PIN = 0;
   localparam int ORD_LIN = 1;
   localparam int ORD_ILV = 2;

   // what a sampled edge does to the array
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;

endpackage

// File: rtl/psram_ctl.sv
module psram_ctl #(
   parameter int LANES = 2
)(
   input  logic             proc_n,
   input  logic             ctrl_n,
   input  logic             adv_n,
   input  logic             gwe_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] lane_n,
   input  logic             ce_main_n,
   input  logic             ce_hi,
   input  logic             ce_lo_n,
   output logic             proc_go,
   output logic             ctrl_go,
   output logic             end_burst,
   output logic             cont,
   output logic             step_req,
   output logic [LANES-1:0] wr_mask,
   output logic             kill_out
);

   logic             sec_ok;
   logic [LANES-1:0] raw_mask;

   assign sec_ok = ce_hi & ~ce_lo_n;

   // processor strobe needs all enables; controller strobe only the secondaries
   assign proc_go   = ~proc_n & ~ce_main_n & sec_ok;
   assign ctrl_go   = ~ctrl_n & proc_n & sec_ok;
   assign end_burst = ~ctrl_n & proc_n & ~sec_ok;

   assign cont     = proc_n & ctrl_n;
   assign step_req = cont & ~adv_n;

   always_comb begin
      if (!gwe_n)
         raw_mask = '1;
      else if (!bwe_n)
         raw_mask = ~lane_n;
      else
         raw_mask = '0;
   end

   // write strobes count for nothing on an edge that samples the processor strobe low
   assign wr_mask  = proc_n ? raw_mask : '0;
   assign kill_out = |wr_mask;

endmodule

// File: rtl/psram_burst.sv
module psram_burst import psram_pkg::*; #(
   parameter int ADDR_W     = 8,
   parameter int BURST_W    = 2,
   parameter int ORDER_MODE = ORD_PIN
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              clear,
   input  logic              step,
   input  logic              ilv,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              active,
   output logic [ADDR_W-1:0] acc_addr
);

   logic [ADDR_W-1:0]  base_q;
   logic [BURST_W-1:0] cnt_q;
   logic               act_q;

   logic [ADDR_W-1:0]  base_eff;
   logic [BURST_W-1:0] cnt_eff;
   logic [BURST_W-1:0] lin_off;
   logic [BURST_W-1:0] ilv_off;
   logic [BURST_W-1:0] off;
   logic               do_step;

   assign do_step  = step & act_q & ~load;
   assign base_eff = load ? addr_in : base_q;

   always_comb begin
      if (load)
         cnt_eff = '0;
      else if (do_step)
         cnt_eff = cnt_q + BURST_W'(1);
      else
         cnt_eff = cnt_q;
   end

   assign lin_off = base_eff[BURST_W-1:0] + cnt_eff;
   assign ilv_off = base_eff[BURST_W-1:0] ^ cnt_eff;

   generate
      if (ORDER_MODE == ORD_LIN) begin : g_lin
         assign off = lin_off;
      end else if (ORDER_MODE == ORD_ILV) begin : g_ilv
         assign off = ilv_off;
      end else begin : g_pin
         assign off = ilv ? ilv_off : lin_off;
      end
   endgenerate

   assign acc_addr = {base_eff[ADDR_W-1:BURST_W], off};
   assign active   = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
      end else if (load) begin
         act_q <= 1'b1;
      end else if (clear) begin
         act_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (load) begin
         base_q <= addr_in;
         cnt_q  <= '0;
      end else if (do_step) begin
         cnt_q  <= cnt_eff;
      end
   end

endmodule

// File: rtl/psram_lane.sv
module psram_lane #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 9
)(
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [LANE_W-1:0] wdata,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] raddr,
   output logic [LANE_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rd_en)
         rdata <= mem[raddr];
   end

endmodule

// File: rtl/pburst_sram.sv
module pburst_sram import psram_pkg::*; #(
   parameter int ADDR_W     = 8,
   parameter int LANE_W     = 9,
   parameter int LANES      = 2,
   parameter int BURST_W    = 2,
   parameter int ORDER_MODE = ORD_PIN
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     proc_strobe_n,
   input  logic                     ctrl_strobe_n,
   input  logic                     adv_n,
   input  logic                     gwe_n,
   input  logic                     bwe_n,
   input  logic [LANES-1:0]         lane_we_n,
   input  logic                     ce_main_n,
   input  logic                     ce_hi,
   input  logic                     ce_lo_n,
   input  logic                     oe_n,
   input  logic                     ilv_order,
   input  logic [LANE_W*LANES-1:0]  din,
   output logic [LANE_W*LANES-1:0]  dout,
   output logic                     dq_drive
);

   localparam int DATA_W = LANE_W * LANES;

   generate
      if (LANE_W < 1 || LANE_W > 9) begin : g_bad_lane
         $error("pburst_sram: LANE_W must lie in 1..9");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("pburst_sram: LANES must be at least 1");
      end
      if (BURST_W < 1 || BURST_W >= ADDR_W) begin : g_bad_burst
         $error("pburst_sram: BURST_W must be 1..ADDR_W-1");
      end
      if (ORDER_MODE < ORD_PIN || ORDER_MODE > ORD_ILV) begin : g_bad_order
         $error("pburst_sram: ORDER_MODE out of range");
      end
   endgenerate

   logic             proc_go, ctrl_go, end_burst, cont, step_req, kill_out;
   logic [LANES-1:0] wr_mask;
   logic             burst_act;
   logic [ADDR_W-1:0] acc_addr;
   acc_kind_e        kind;

   logic              rd_pend_q;
   logic [ADDR_W-1:0] rd_addr_q;
   logic              out_valid_q;

   psram_ctl #(.LANES(LANES)) u_ctl (
      .proc_n    (proc_strobe_n),
      .ctrl_n    (ctrl_strobe_n),
      .adv_n     (adv_n),
      .gwe_n     (gwe_n),
      .bwe_n     (bwe_n),
      .lane_n    (lane_we_n),
      .ce_main_n (ce_main_n),
      .ce_hi     (ce_hi),
      .ce_lo_n   (ce_lo_n),
      .proc_go   (proc_go),
      .ctrl_go   (ctrl_go),
      .end_burst (end_burst),
      .cont      (cont),
      .step_req  (step_req),
      .wr_mask   (wr_mask),
      .kill_out  (kill_out)
   );

   psram_burst #(
      .ADDR_W     (ADDR_W),
      .BURST_W    (BURST_W),
      .ORDER_MODE (ORDER_MODE)
   ) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (proc_go | ctrl_go),
      .clear    (end_burst),
      .step     (step_req),
      .ilv      (ilv_order),
      .addr_in  (addr),
      .active   (burst_act),
      .acc_addr (acc_addr)
   );

   // classify the edge
   always_comb begin
      if (proc_go)
         kind = ACC_READ;
      else if (ctrl_go || (cont && burst_act))
         kind = kill_out ? ACC_WRITE : ACC_READ;
      else
         kind = ACC_NONE;
   end

   // read pipeline: address stage then data-out stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend_q   <= 1'b0;
         out_valid_q <= 1'b0;
      end else begin
         rd_pend_q   <= (kind == ACC_READ);
         out_valid_q <= rd_pend_q & ~kill_out;
      end
   end

   always_ff @(posedge clk) begin
      rd_addr_q <= acc_addr;
   end

   generate
      for (genvar li = 0; li < LANES; li++) begin : g_lane
         psram_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .we    ((kind == ACC_WRITE) & wr_mask[li]),
            .waddr (acc_addr),
            .wdata (din[li*LANE_W +: LANE_W]),
            .rd_en (rd_pend_q),
            .raddr (rd_addr_q),
            .rdata (dout[li*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign dq_drive = out_valid_q & ~oe_n;

   logic unused_w;
   assign unused_w = (DATA_W == 0);

endmodule

// File: rtl/pburst_sram_chk.sv
module pburst_sram_chk #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 2
)(
   input logic              clk,
   input logic              rst_n,
   input logic              proc_strobe_n,
   input logic              ctrl_strobe_n,
   input logic              adv_n,
   input logic              gwe_n,
   input logic              bwe_n,
   input logic [LANES-1:0]  lane_we_n,
   input logic              ce_main_n,
   input logic              ce_hi,
   input logic              ce_lo_n,
   input logic              oe_n,
   input logic              dq_drive,
   input logic              burst_act,
   input logic              rd_pend_q,
   input logic [ADDR_W-1:0] rd_addr_q
);

   logic wr_seen;
   assign wr_seen = proc_strobe_n & (~gwe_n | (~bwe_n & ~(&lane_we_n)));

   // R9
   oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_drive);

   // R8
   write_kills_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_seen |=> !dq_drive);

   // R2
   proc_start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strobe_n && !ce_main_n && ce_hi && !ce_lo_n) |=> rd_pend_q);

   // R4
   main_ce_blocks_proc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!proc_strobe_n && ce_main_n && !burst_act) |=> !burst_act);

   // R5
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && proc_strobe_n && ctrl_strobe_n && adv_n) |=> $stable(rd_addr_q));

   // R5
   step_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_act && proc_strobe_n && ctrl_strobe_n && !adv_n) |=> !$stable(rd_addr_q));

endmodule

bind pburst_sram pburst_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .proc_strobe_n (proc_strobe_n),
   .ctrl_strobe_n (ctrl_strobe_n),
   .adv_n         (adv_n),
   .gwe_n         (gwe_n),
   .bwe_n         (bwe_n),
   .lane_we_n     (lane_we_n),
   .ce_main_n     (ce_main_n),
   .ce_hi         (ce_hi),
   .ce_lo_n       (ce_lo_n),
   .oe_n          (oe_n),
   .dq_drive      (dq_drive),
   .burst_act     (burst_act),
   .rd_pend_q     (rd_pend_q),
   .rd_addr_q     (rd_addr_q)
);

// File: tb/pburst_sram_test.sv
module pburst_sram_test;

   localparam int AW = 8;
   localparam int LW = 9;
   localparam int NL = 2;
   localparam int DW = LW * NL;
   localparam int NW = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [AW-1:0] addr;
   logic          proc_n, ctrl_n, adv_n, gwe_n, bwe_n;
   logic [NL-1:0] lane_n;
   logic          ce_main_n, ce_hi, ce_lo_n, oe_n, ilv;
   logic [DW-1:0] din;
   logic [DW-1:0] dout;
   logic          dq_drive;

   logic [DW-1:0] model [NW];
   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pburst_sram uut (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .proc_strobe_n(proc_n), .ctrl_strobe_n(ctrl_n), .adv_n(adv_n),
      .gwe_n(gwe_n), .bwe_n(bwe_n), .lane_we_n(lane_n),
      .ce_main_n(ce_main_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
      .oe_n(oe_n), .ilv_order(ilv), .din(din), .dout(dout), .dq_drive(dq_drive)
   );

   function automatic logic [DW-1:0] pat(input int a, input int salt);
      return DW'(a * 613 + salt * 97 + 11);
   endfunction

   function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] b, input int c, input logic il);
      logic [1:0] o;
      o = il ? (b[1:0] ^ 2'(c)) : 2'(b[1:0] + 2'(c));
      return {b[AW-1:2], o};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      proc_n = 1; ctrl_n = 1; adv_n = 1; gwe_n = 1; bwe_n = 1; lane_n = '1;
      ce_main_n = 0; ce_hi = 1; ce_lo_n = 0; oe_n = 0;
   endtask

   task automatic desel();
      idle(); ctrl_n = 0; ce_hi = 0;
      step();
      idle();
   endtask

   task automatic chk_val(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic chk_bit(input string tag, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   // single read from a deselected state; result taken after the second edge
   task automatic read_single(input logic [AW-1:0] a, input string tag);
      idle(); proc_n = 0; addr = a;
      step();
      chk_bit({tag, " R1 no drive after start edge"}, dq_drive, 1'b0);
      desel();
      chk_bit({tag, " R1 drive one edge later"}, dq_drive, 1'b1);
      chk_val({tag, " R10 read data"}, dout, model[a]);
   endtask

   task automatic write_burst(input logic [AW-1:0] b, input logic il, input int salt);
      logic [AW-1:0] a;
      ilv = il;
      idle(); ctrl_n = 0; addr = b; gwe_n = 0; din = pat(b, salt);
      model[b] = din;
      step();
      chk_bit("R8 no drive on write", dq_drive, 1'b0);
      for (int c = 1; c < 4; c++) begin
         a = beat_addr(b, c, il);
         idle(); adv_n = 0; gwe_n = 0; din = pat(a, salt);
         model[a] = din;
         step();
      end
      desel();
   endtask

   task automatic read_burst(input logic [AW-1:0] b, input logic il, input logic junk);
      ilv = il;
      idle(); proc_n = 0; addr = b; adv_n = 0;
      if (junk) begin
         gwe_n = 0; ctrl_n = 0; din = ~model[b];
      end
      step();
      for (int c = 1; c < 4; c++) begin
         idle(); adv_n = 0;
         step();
         chk_bit("R1 burst drive", dq_drive, 1'b1);
         chk_val(junk ? "R2 R6 burst beat" : "R5 R6 burst beat", dout, model[beat_addr(b, c - 1, il)]);
      end
      idle(); adv_n = 1;
      step();
      chk_val("R6 last beat", dout, model[beat_addr(b, 3, il)]);
      step();
      chk_val("R5 hold repeats", dout, model[beat_addr(b, 3, il)]);
      desel();
      chk_val("R5 hold repeats again", dout, model[beat_addr(b, 3, il)]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      rst_n = 0; addr = '0; din = '0; ilv = 0;
      idle();
      repeat (3) step();
      rst_n = 1;
      chk_bit("R10 reset drive", dq_drive, 1'b0);
      step();
      chk_bit("R10 no burst after reset", dq_drive, 1'b0);

      // R3 R5 R6: burst writes over every address in both orders
      for (int g = 0; g < NW / 4; g++)
         write_burst(AW'(4 * g + (g % 4)), 1'(g % 2), 1);

      // R5 R6 R2: burst reads from every base in both orders
      for (int b = 0; b < NW; b++) begin
         read_burst(AW'(b), 1'b0, 1'(b % 2));
         read_burst(AW'(b), 1'b1, 1'(b % 3 == 0));
      end

      // R7 lane writes
      d = 18'h2A5A5;
      idle(); ctrl_n = 0; addr = 8'h55; bwe_n = 0; lane_n = 2'b10; din = d;
      step(); model[8'h55][LW-1:0] = d[LW-1:0]; desel();
      read_single(8'h55, "R7 lane0 only");
      d = 18'h1C3C3;
      idle(); ctrl_n = 0; addr = 8'h55; bwe_n = 0; lane_n = 2'b01; din = d;
      step(); model[8'h55][DW-1:LW] = d[DW-1:LW]; desel();
      read_single(8'h55, "R7 lane1 only");
      idle(); ctrl_n = 0; addr = 8'h55; bwe_n = 0; lane_n = 2'b11; din = 18'h3FFFF;
      step(); desel();
      chk_bit("R7 all lanes off is read drive", dq_drive, 1'b1);
      chk_val("R7 all lanes off is read data", dout, model[8'h55]);
      idle(); ctrl_n = 0; addr = 8'h55; lane_n = 2'b00; din = 18'h00000;
      step(); desel();
      chk_val("R7 bwe high is read", dout, model[8'h55]);
      read_single(8'h55, "R7 unchanged");

      // R4 chip enable rules
      idle(); ce_main_n = 1; proc_n = 0; addr = 8'h20;
      step(); idle(); adv_n = 0; step();
      chk_bit("R4 main ce blocks proc start", dq_drive, 1'b0);
      idle(); ce_main_n = 1; ctrl_n = 0; gwe_n = 0; addr = 8'h21; din = 18'h12345;
      step(); model[8'h21] = 18'h12345; desel();
      read_single(8'h21, "R4 main ce passes ctrl start");
      idle(); ce_hi = 0; ctrl_n = 0; gwe_n = 0; addr = 8'h21; din = 18'h0F0F0;
      step(); desel();
      read_single(8'h21, "R4 ce_hi low blocks write");
      idle(); ce_lo_n = 1; proc_n = 0; addr = 8'h22;
      step(); idle(); adv_n = 0; step();
      chk_bit("R4 ce_lo_n high blocks proc start", dq_drive, 1'b0);
      idle(); proc_n = 0; addr = 8'h23; step();
      desel();
      idle(); adv_n = 0; step(); step();
      chk_bit("R4 deselect ends burst", dq_drive, 1'b0);

      // R8 write kills a pending read result, R10 read after write
      idle(); proc_n = 0; addr = 8'h30; step();
      idle(); gwe_n = 0; din = 18'h2BEEF;
      step(); model[8'h30] = 18'h2BEEF;
      chk_bit("R8 write kills drive", dq_drive, 1'b0);
      desel();
      read_single(8'h30, "R8 R10 written word");

      // R10 write then read the same address on the next edge
      idle(); ctrl_n = 0; addr = 8'h31; gwe_n = 0; din = 18'h15A5A;
      step(); model[8'h31] = 18'h15A5A;
      idle(); adv_n = 1; step();
      desel();
      chk_val("R10 read right after write", dout, model[8'h31]);

      // R9 output enable gate is combinational
      idle(); proc_n = 0; addr = 8'h40; step();
      idle(); ctrl_n = 0; ce_hi = 0; oe_n = 1; step();
      chk_bit("R9 oe high no drive", dq_drive, 1'b0);
      oe_n = 0; #1;
      chk_bit("R9 oe low drives without edge", dq_drive, 1'b1);
      chk_val("R9 held data", dout, model[8'h40]);
      idle();

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule